// File: doc/BRIEF.md
# I2C EEPROM Target with One-Time Write Lock

This block is an I2C target that stands in for a 256-byte serial EEPROM with a one-byte word address. It listens on a group of eight memory addresses. It supports byte and multi-byte writes, current-address reads, random reads and sequential reads. All accesses go through one internal word pointer, which steps by one after every byte and wraps past the top of the array.

A second group of eight bus addresses, 0x20 below the memory group, holds a one-time protect latch. On that group the target acknowledges a write-direction address with no data, so a controller can use a quick write to detect it. It refuses any read-direction address. A completed data byte written there sets the latch. From then on the upper half of the array ignores writes while the lower half stays writable, and the target no longer answers anywhere in the control group. Only reset clears the latch. Reset also clears the array.

The block samples the bus with its own clock. SDA is driven only through an open-drain enable. The target never stretches SCL, so SCL is an input only.

Top module: `eep_target`

## Requirements
- R1: The 7-bit addresses 0x50 to 0x57 are acknowledged in both directions. Neighbouring addresses such as 0x4F and 0x58 are not acknowledged.
- R2: A write transaction made of the device address, a word address and a data byte stores that byte. A random read of the same word address returns it.
- R3: The word pointer steps by one after each byte read or written, and 0xFF is followed by 0x00. A read without a word address begins where the previous access stopped.
- R4: A read continues for as long as the controller acknowledges each byte. After the controller's NACK the target leaves SDA released.
- R5: On 0x30 to 0x37 the target acknowledges a write-direction address byte and refuses a read-direction address byte.
- R6: A quick write on the control group (an address byte followed directly by STOP or repeated START) neither sets the latch nor changes the array.
- R7: A data byte written to a control address is acknowledged and sets the latch. Once the latch is set, no control address is acknowledged again.
- R8: While the latch is set, writes to word addresses 0x80 to 0xFF are acknowledged but leave the stored byte unchanged. Addresses 0x00 to 0x7F are still written.
- R9: A START or a STOP returns the target to address matching from any point, including mid-byte and between data bytes. Bits already shifted in are not stored.
- R10: Reset releases SDA, clears the latch and sets every array byte to 0x00.
- R11: The target changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sampling clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe_o | output | 1 | SDA pull-down enable; 1 drives the line low |

## Verification
The hardest state to reach is the latched one. It takes a full write to a control address, and it changes both which addresses are answered and which array writes take effect. The bench first probes the control group with quick writes and then shows, by reading back an upper-half byte, that those probes left writes enabled. Only then does it send the locking byte. It then writes across the 0x7F/0x80 boundary and reads both bytes back. Finally it resets the block and shows that the control group is answered again.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WADR, ST_WACK,
    ST_WDAT, ST_DACK, ST_RDAT, ST_RACK, ST_LDAT, ST_LACK
  } link_st_e;

  typedef enum logic [1:0] {
    TGT_NONE, TGT_MEM_W, TGT_MEM_R, TGT_CTL
  } tgt_e;
endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int NLINE = 2;

  logic [NLINE-1:0] raw, synced, prev;
  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < NLINE; g++) begin : g_line
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pipe    <= '1;
        prev[g] <= 1'b1;
      end else begin
        pipe    <= {pipe[STAGES-2:0], raw[g]};
        prev[g] <= pipe[STAGES-1];
      end
    end
    assign synced[g] = pipe[STAGES-1];
  end

  assign scl_o      = synced[1];
  assign sda_o      = synced[0];
  assign scl_rise_o = synced[1] & ~prev[1];
  assign scl_fall_o = ~synced[1] & prev[1];
  // SDA edges while SCL held high
  assign start_o    = synced[1] & prev[1] & prev[0] & ~synced[0];
  assign stop_o     = synced[1] & prev[1] & ~prev[0] & synced[0];
endmodule

// File: rtl/eep_mem.sv
module eep_mem #(
  parameter int AW = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [AW-1:0]             waddr_i,
  input  logic [eep_pkg::BYTE_W-1:0] wdata_i,
  input  logic                      lock_i,
  input  logic [AW-1:0]             raddr_i,
  output logic [eep_pkg::BYTE_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [eep_pkg::BYTE_W-1:0] mem [DEPTH];
  logic wr_ok;

  // upper half frozen once locked
  assign wr_ok = we_i & ~(lock_i & waddr_i[AW-1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_ok) begin
      mem[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/eep_link.sv
module eep_link
  import eep_pkg::*;
#(
  parameter int         AW       = 8,
  parameter logic [6:0] MEM_BASE = 7'h50,
  parameter logic [6:0] CTL_BASE = 7'h30,
  parameter int         SEL_W    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [BYTE_W-1:0] rdata_i,
  output logic              sda_oe_o,
  output logic              we_o,
  output logic [AW-1:0]     waddr_o,
  output logic [BYTE_W-1:0] wdata_o,
  output logic [AW-1:0]     ptr_o,
  output logic              lock_o,
  output link_st_e          state_o
);
  localparam int CW = $clog2(BYTE_W + 1);
  localparam logic [CW-1:0] FULL = CW'(BYTE_W);

  link_st_e          st;
  tgt_e              tgt;
  logic [BYTE_W-1:0] sh, tx;
  logic [CW-1:0]     cnt;
  logic [AW-1:0]     ptr;
  logic              lock, oe, we;
  logic [AW-1:0]     wadr;
  logic [BYTE_W-1:0] wdat;

  logic mem_hit, ctl_hit, rw, byte_done;
  assign mem_hit   = sh[7:SEL_W+1] == MEM_BASE[6:SEL_W];
  assign ctl_hit   = sh[7:SEL_W+1] == CTL_BASE[6:SEL_W];
  assign rw        = sh[0];
  assign byte_done = scl_fall_i && (cnt == FULL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st   <= ST_IDLE;
      tgt  <= TGT_NONE;
      sh   <= '0;
      tx   <= '0;
      cnt  <= '0;
      ptr  <= '0;
      lock <= 1'b0;
      oe   <= 1'b0;
      we   <= 1'b0;
      wadr <= '0;
      wdat <= '0;
    end else begin
      we <= 1'b0;
      if (start_i) begin
        st  <= ST_ADDR;
        cnt <= '0;
        oe  <= 1'b0;
      end else if (stop_i) begin
        st <= ST_IDLE;
        oe <= 1'b0;
      end else begin
        unique case (st)
          ST_ADDR, ST_WADR, ST_WDAT, ST_LDAT: begin
            if (scl_rise_i) begin
              sh  <= {sh[BYTE_W-2:0], sda_i};
              cnt <= cnt + CW'(1);
            end else if (byte_done) begin
              cnt <= '0;
              oe  <= 1'b1;
              unique case (st)
                ST_ADDR: begin
                  if (mem_hit) begin
                    tgt <= rw ? TGT_MEM_R : TGT_MEM_W;
                    st  <= ST_AACK;
                  end else if (ctl_hit && !rw && !lock) begin
                    tgt <= TGT_CTL;
                    st  <= ST_AACK;
                  end else begin
                    oe <= 1'b0;
                    st <= ST_IDLE;
                  end
                end
                ST_WADR: begin
                  ptr <= sh[AW-1:0];
                  st  <= ST_WACK;
                end
                ST_WDAT: begin
                  we   <= 1'b1;
                  wadr <= ptr;
                  wdat <= sh;
                  ptr  <= ptr + AW'(1);
                  st   <= ST_DACK;
                end
                default: begin
                  lock <= 1'b1;
                  st   <= ST_LACK;
                end
              endcase
            end
          end
          ST_AACK: begin
            if (scl_fall_i) begin
              cnt <= '0;
              unique case (tgt)
                TGT_MEM_W: begin oe <= 1'b0; st <= ST_WADR; end
                TGT_CTL:   begin oe <= 1'b0; st <= ST_LDAT; end
                TGT_MEM_R: begin
                  tx  <= rdata_i;
                  oe  <= ~rdata_i[BYTE_W-1];
                  ptr <= ptr + AW'(1);
                  st  <= ST_RDAT;
                end
                default: begin oe <= 1'b0; st <= ST_IDLE; end
              endcase
            end
          end
          ST_WACK, ST_DACK: begin
            if (scl_fall_i) begin
              oe  <= 1'b0;
              cnt <= '0;
              st  <= ST_WDAT;
            end
          end
          ST_LACK: begin
            if (scl_fall_i) begin
              oe <= 1'b0;
              st <= ST_IDLE;
            end
          end
          ST_RDAT: begin
            if (scl_rise_i) begin
              cnt <= cnt + CW'(1);
            end else if (scl_fall_i) begin
              if (cnt == FULL) begin
                oe  <= 1'b0;
                cnt <= '0;
                st  <= ST_RACK;
              end else begin
                oe <= ~tx[BYTE_W-2];
                tx <= {tx[BYTE_W-2:0], 1'b0};
              end
            end
          end
          ST_RACK: begin
            if (scl_rise_i) begin
              sh <= {sh[BYTE_W-2:0], sda_i};
            end else if (scl_fall_i) begin
              if (!sh[0]) begin
                tx  <= rdata_i;
                oe  <= ~rdata_i[BYTE_W-1];
                ptr <= ptr + AW'(1);
                cnt <= '0;
                st  <= ST_RDAT;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o = oe;
  assign we_o     = we;
  assign waddr_o  = wadr;
  assign wdata_o  = wdat;
  assign ptr_o    = ptr;
  assign lock_o   = lock;
  assign state_o  = st;
endmodule

// File: rtl/eep_target.sv
module eep_target
  import eep_pkg::*;
#(
  parameter int         AW          = 8,
  parameter logic [6:0] MEM_BASE    = 7'h50,
  parameter logic [6:0] CTL_BASE    = 7'h30,
  parameter int         SEL_W       = 3,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);
  logic              scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  logic              mem_we, lock;
  logic [AW-1:0]     mem_waddr, rd_ptr;
  logic [BYTE_W-1:0] mem_wdata, mem_rdata;
  link_st_e          link_st;

  eep_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (bus_start),
    .stop_o     (bus_stop)
  );

  eep_link #(
    .AW(AW), .MEM_BASE(MEM_BASE), .CTL_BASE(CTL_BASE), .SEL_W(SEL_W)
  ) u_link (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sda_i      (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (bus_start),
    .stop_i     (bus_stop),
    .rdata_i    (mem_rdata),
    .sda_oe_o   (sda_oe_o),
    .we_o       (mem_we),
    .waddr_o    (mem_waddr),
    .wdata_o    (mem_wdata),
    .ptr_o      (rd_ptr),
    .lock_o     (lock),
    .state_o    (link_st)
  );

  eep_mem #(.AW(AW)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mem_we),
    .waddr_i (mem_waddr),
    .wdata_i (mem_wdata),
    .lock_i  (lock),
    .raddr_i (rd_ptr),
    .rdata_o (mem_rdata)
  );
endmodule

// File: rtl/eep_target_chk.sv
module eep_target_chk
  import eep_pkg::*;
#(
  parameter int AW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          scl_s,
  input logic          sda_oe,
  input logic          lock,
  input logic          we,
  input logic [AW-1:0] wadr,
  input logic [AW-1:0] ptr,
  input link_st_e      state
);
  a_r7_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock |=> lock);

  a_r7_lock_from_ctl_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock) |-> $past(state) == ST_LDAT);

  a_r11_drive_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe != $past(sda_oe)) |-> !$past(scl_s));

  a_r9_idle_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE) |-> !sda_oe);

  a_r3_ptr_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we |-> (ptr == wadr + AW'(1)));
endmodule

bind eep_target eep_target_chk #(.AW(AW)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .scl_s  (scl_s),
  .sda_oe (sda_oe_o),
  .lock   (lock),
  .we     (mem_we),
  .wadr   (mem_waddr),
  .ptr    (rd_ptr),
  .state  (link_st)
);

// File: tb/eep_target_test.sv
module eep_target_test;
  localparam int QTR = 6;
  localparam int WD_CYC = 150000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic scl_tb = 1'b1;
  logic sda_tb = 1'b1;
  logic sda_oe, sda_line;
  int   n_chk = 0, n_bad = 0, r11_viol = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  assign sda_line = sda_tb & ~sda_oe;

  eep_target uut (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .scl_i    (scl_tb),
    .sda_i    (sda_line),
    .sda_oe_o (sda_oe)
  );

  typedef struct packed {
    logic [1:0] op;    // 0 probe-w, 1 probe-r, 2 write, 3 random read
    logic [6:0] dev;
    logic [7:0] wa;
    logic [7:0] d;
    logic       ack;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 7'h50, 8'h00, 8'h00, 1'b1, 8'h00, 4'd1},  // R1
    '{2'd1, 7'h57, 8'h00, 8'h00, 1'b1, 8'h00, 4'd1},  // R1
    '{2'd0, 7'h58, 8'h00, 8'h00, 1'b0, 8'h00, 4'd1},  // R1
    '{2'd0, 7'h4F, 8'h00, 8'h00, 1'b0, 8'h00, 4'd1},  // R1
    '{2'd0, 7'h33, 8'h00, 8'h00, 1'b1, 8'h00, 4'd5},  // R5 quick write
    '{2'd1, 7'h35, 8'h00, 8'h00, 1'b0, 8'h00, 4'd5},  // R5 read refused
    '{2'd2, 7'h52, 8'h10, 8'hA5, 1'b1, 8'h00, 4'd2},  // R2
    '{2'd3, 7'h50, 8'h10, 8'h00, 1'b1, 8'hA5, 4'd2},  // R2
    '{2'd2, 7'h50, 8'h90, 8'h3C, 1'b1, 8'h00, 4'd6},  // R6 upper half open
    '{2'd3, 7'h55, 8'h90, 8'h00, 1'b1, 8'h3C, 4'd6}   // R6
  };

  task automatic q();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_tb = 1'b1; q(); scl_tb = 1'b1; q(); sda_tb = 1'b0; q(); scl_tb = 1'b0; q();
  endtask

  task automatic bus_stop();
    sda_tb = 1'b0; q(); scl_tb = 1'b1; q(); sda_tb = 1'b1; q();
  endtask

  task automatic put_bit(input logic b);
    sda_tb = b; q(); scl_tb = 1'b1; q(); q(); scl_tb = 1'b0; q();
  endtask

  task automatic get_bit(output logic b);
    sda_tb = 1'b1; q(); scl_tb = 1'b1; q(); b = sda_line; q(); scl_tb = 1'b0; q();
  endtask

  task automatic wb(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic rb(output logic [7:0] v, input logic more);
    for (int i = 7; i >= 0; i--) begin
      logic b;
      get_bit(b);
      v[i] = b;
    end
    put_bit(~more);
  endtask

  task automatic rand_read(input logic [6:0] dev, input logic [7:0] wa,
                           output logic [7:0] v, output logic ok);
    logic a0, a1, a2;
    bus_start(); wb({dev, 1'b0}, a0); wb(wa, a1);
    bus_start(); wb({dev, 1'b1}, a2); rb(v, 1'b0); bus_stop();
    ok = a0 & a1 & a2;
  endtask

  task automatic write1(input logic [6:0] dev, input logic [7:0] wa,
                        input logic [7:0] d, output logic ok);
    logic a0, a1, a2;
    bus_start(); wb({dev, 1'b0}, a0); wb(wa, a1); wb(d, a2); bus_stop();
    ok = a0 & a1 & a2;
  endtask

  task automatic probe(input logic [6:0] dev, input logic rd, output logic a);
    logic [7:0] v;
    bus_start(); wb({dev, rd}, a);
    if (a && rd) rb(v, 1'b0);
    bus_stop();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // R11 monitor: drive changes only while SCL has been low
  logic prev_oe = 1'b0, prev_scl = 1'b1;
  always @(negedge clk) begin
    if (rst_ni && (sda_oe != prev_oe) && scl_tb && prev_scl) r11_viol++;
    prev_oe  <= sda_oe;
    prev_scl <= scl_tb;
  end

  initial begin
    repeat (WD_CYC) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic ok, a, a0, a1, a2, a3, a4, a5;
    repeat (5) @(negedge clk);
    chk("R10 oe in reset", sda_oe, 0);
    rst_ni = 1'b1;
    q();
    chk("R10 oe after reset", sda_oe, 0);
    rand_read(7'h50, 8'h20, v, ok);
    chk("R10 array cleared", v, 8'h00);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
      case (VEC[i].op)
        2'd0: begin probe(VEC[i].dev, 1'b0, a); chk(tag, a, VEC[i].ack); end
        2'd1: begin probe(VEC[i].dev, 1'b1, a); chk(tag, a, VEC[i].ack); end
        2'd2: begin write1(VEC[i].dev, VEC[i].wa, VEC[i].d, ok); chk(tag, ok, VEC[i].ack); end
        default: begin
          rand_read(VEC[i].dev, VEC[i].wa, v, ok);
          chk(tag, ok, VEC[i].ack);
          chk(tag, v, VEC[i].exp);
        end
      endcase
    end

    // R3 multi-byte write wrapping 0xFF -> 0x00
    bus_start(); wb({7'h51, 1'b0}, a0); wb(8'hFE, a1);
    wb(8'h11, a2); wb(8'h22, a3); wb(8'h33, a4); wb(8'h44, a5); bus_stop();
    chk("R3 wrap write acks", a0 & a1 & a2 & a3 & a4 & a5, 1);
    // R3/R4 sequential read across the wrap
    bus_start(); wb({7'h51, 1'b0}, a0); wb(8'hFE, a1);
    bus_start(); wb({7'h51, 1'b1}, a2);
    rb(v, 1'b1); chk("R3 seq 0xFE", v, 8'h11);
    rb(v, 1'b1); chk("R3 seq 0xFF", v, 8'h22);
    rb(v, 1'b0); chk("R3 seq 0x00", v, 8'h33);
    q();
    chk("R4 released after nack", sda_oe, 0);
    bus_stop();
    // R3 current-address read continues at 0x01
    bus_start(); wb({7'h51, 1'b1}, a); rb(v, 1'b0); bus_stop();
    chk("R3 current address", v, 8'h44);

    // R9 repeated START between data bytes is an address
    bus_start(); wb({7'h50, 1'b0}, a0); wb(8'h40, a1); wb(8'h77, a2);
    bus_start(); wb({7'h33, 1'b0}, a3); bus_stop();
    chk("R9 restart ack", a3, 1);
    rand_read(7'h50, 8'h40, v, ok);
    chk("R9 data kept", v, 8'h77);
    rand_read(7'h50, 8'h41, v, ok);
    chk("R9 addr not stored", v, 8'h00);
    // R9 STOP mid-byte
    bus_start(); put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b0); bus_stop();
    probe(7'h50, 1'b0, a);
    chk("R9 after mid-byte stop", a, 1);
    probe(7'h34, 1'b0, a);
    chk("R6 ctl still answers", a, 1);

    // R7 lock command
    bus_start(); wb({7'h36, 1'b0}, a0); wb(8'h00, a1); bus_stop();
    chk("R7 lock byte acked", a0 & a1, 1);
    probe(7'h30, 1'b0, a);
    chk("R7 ctl 0x30 after lock", a, 0);
    probe(7'h37, 1'b0, a);
    chk("R7 ctl 0x37 after lock", a, 0);

    // R8 locked writes
    write1(7'h50, 8'h90, 8'hEE, ok);
    chk("R8 upper write acked", ok, 1);
    rand_read(7'h50, 8'h90, v, ok);
    chk("R8 upper unchanged", v, 8'h3C);
    write1(7'h50, 8'h10, 8'h5A, ok);
    rand_read(7'h50, 8'h10, v, ok);
    chk("R8 lower writable", v, 8'h5A);
    bus_start(); wb({7'h50, 1'b0}, a0); wb(8'h7F, a1); wb(8'h61, a2); wb(8'h62, a3); bus_stop();
    chk("R8 boundary acks", a0 & a1 & a2 & a3, 1);
    rand_read(7'h50, 8'h7F, v, ok);
    chk("R8 0x7F written", v, 8'h61);
    rand_read(7'h50, 8'h80, v, ok);
    chk("R8 0x80 kept", v, 8'h00);

    // R10 reset clears lock and array
    @(negedge clk); rst_ni = 1'b0;
    repeat (4) @(negedge clk); rst_ni = 1'b1;
    q();
    probe(7'h31, 1'b0, a);
    chk("R10 lock cleared", a, 1);
    rand_read(7'h50, 8'h10, v, ok);
    chk("R10 array reset", v, 8'h00);

    chk("R11 drive edges with SCL high", r11_viol, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule